// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns pointer events into a fixed five-byte report and queues the bytes for a host that drains them one at a time. Each event carries three button levels and signed X and Y motion deltas. The first byte is a header whose low three bits are set while the buttons are released. The second byte is the horizontal motion, clipped to a signed byte. The third byte is the vertical motion with its sign flipped and clipped in the same way. Two zero bytes close the packet.

When an event is accepted, a small sequencer latches the packet. It then offers the bytes to a circular queue, one per clock, in header, X, Y, zero, zero order. The queue drops any byte that arrives while it is full. The host sees the oldest queued byte on its data output, sees a flag while anything is queued, and pops the byte with a read strobe. A synchronous clear empties the queue and abandons a packet that is partly sent.

Top module: `mouse_pkt_enc`

## Requirements
- R1: The header byte is 0x87 with bit 2 cleared while the left button is pressed, bit 1 cleared while the middle button is pressed, and bit 0 cleared while the right button is pressed.
- R2: The second byte is the X delta clipped to the range -127..+127, in 8-bit two's complement (+128 and above give 0x7F, -128 and below give 0x81).
- R3: The third byte is the negated Y delta clipped to -127..+127, in 8-bit two's complement.
- R4: The fourth and fifth bytes are 0x00. The five bytes enter the queue in the order header, X, Y, zero, zero, one per clock, starting the cycle after the event is accepted.
- R5: The queue is first-in first-out over a circular store of DEPTH bytes whose pointers wrap to zero. `rdByte` shows the oldest byte, and `dataAvail` stays high while at least one byte remains.
- R6: A byte offered while the queue holds DEPTH bytes is discarded and the count is unchanged. An event with fewer than five free slots still queues its leading bytes until the queue is full.
- R7: A read strobe on an empty queue has no effect. `rdByte` reads 0x00 while the queue is empty.
- R8: `clear` empties the queue on the next clock edge and abandons any packet in progress.
- R9: An event strobe that arrives while a packet is still being queued is ignored.
- R10: After reset the queue is empty, `dataAvail` is low and `rdByte` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous queue flush |
| evtStrobe | input | 1 | One-cycle pulse that marks a new pointer event |
| dx | input | DELTA_W | Signed horizontal motion |
| dy | input | DELTA_W | Signed vertical motion |
| btnLeft | input | 1 | Left button level, 1 = pressed |
| btnMiddle | input | 1 | Middle button level, 1 = pressed |
| btnRight | input | 1 | Right button level, 1 = pressed |
| rdStrobe | input | 1 | Pops the byte shown on rdByte |
| rdByte | output | 8 | Oldest queued byte, or 0x00 when empty |
| dataAvail | output | 1 | High while the queue holds at least one byte |

## Verification
The encoder is driven with button combinations that each clear a different header bit, and with deltas inside the range, exactly at ±127, one step past it, and at the extremes of the input width. These cases separate correct clipping from plain truncation and show that the Y sign is flipped before the clip. Queue behaviour is checked by overfilling across a packet boundary, reading an empty queue, clearing mid-packet and sending a second event during a burst. Each of these cases shows whether a byte was lost, duplicated or accepted when it should not have been.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int PKT_BYTES = 5;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic             load;
    logic             push;
    logic [SEL_W-1:0] sel;
    logic             pop;
    logic             clr;
  } mpeCtrl_t;
endpackage

// File: rtl/mpe_ctrl.sv
module mpe_ctrl
  import mpe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear,
  input  logic     evtStrobe,
  input  logic     rdStrobe,
  input  logic     qEmpty,
  input  logic     qFull,
  output mpeCtrl_t ctrl
);
  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(PKT_BYTES - 1);

  logic             busy;
  logic [SEL_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (clear) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy) begin
      if (evtStrobe) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end else if (idx == LAST_IDX) begin
      busy <= 1'b0;
      idx  <= '0;
    end else begin
      idx <= idx + 1'b1;
    end
  end

  always_comb begin
    ctrl.clr  = clear;
    ctrl.load = evtStrobe & ~busy & ~clear;
    ctrl.push = busy & ~qFull & ~clear;
    ctrl.sel  = idx;
    ctrl.pop  = rdStrobe & ~qEmpty & ~clear;
  end
endmodule

// File: rtl/mpe_datapath.sv
module mpe_datapath
  import mpe_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DELTA_W = 10,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  mpeCtrl_t                  ctrl,
  input  logic signed [DELTA_W-1:0] dx,
  input  logic signed [DELTA_W-1:0] dy,
  input  logic                      btnLeft,
  input  logic                      btnMiddle,
  input  logic                      btnRight,
  output logic [7:0]                rdByte,
  output logic                      qEmpty,
  output logic                      qFull,
  output logic [CNT_W-1:0]          qCount
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  function automatic logic [7:0] clip8(input logic signed [DELTA_W:0] v);
    if (v > 127)       return 8'h7F;
    else if (v < -127) return 8'h81;
    else               return v[7:0];
  endfunction

  logic signed [DELTA_W:0] xWide, yNeg;
  logic [7:0] pktHead, pktX, pktY, pushByte;

  always_comb begin
    xWide = (DELTA_W+1)'(dx);
    yNeg  = -((DELTA_W+1)'(dy));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pktHead <= 8'h87;
      pktX    <= '0;
      pktY    <= '0;
    end else if (ctrl.load) begin
      pktHead <= 8'h87 ^ {5'b0, btnLeft, btnMiddle, btnRight};
      pktX    <= clip8(xWide);
      pktY    <= clip8(yNeg);
    end
  end

  always_comb begin
    case (ctrl.sel)
      SEL_W'(0): pushByte = pktHead;
      SEL_W'(1): pushByte = pktX;
      SEL_W'(2): pushByte = pktY;
      default:   pushByte = 8'h00;
    endcase
  end

  logic [7:0]       store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (ctrl.push) store[wrPtr] <= pushByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else if (ctrl.clr) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (ctrl.push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (ctrl.pop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({ctrl.push, ctrl.pop})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  always_comb begin
    qEmpty = (qCount == '0);
    qFull  = (qCount == CNT_FULL);
    rdByte = qEmpty ? 8'h00 : store[rdPtr];
  end
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DELTA_W = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      evtStrobe,
  input  logic signed [DELTA_W-1:0] dx,
  input  logic signed [DELTA_W-1:0] dy,
  input  logic                      btnLeft,
  input  logic                      btnMiddle,
  input  logic                      btnRight,
  input  logic                      rdStrobe,
  output logic [7:0]                rdByte,
  output logic                      dataAvail
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  mpeCtrl_t         ctrl;
  logic             qEmpty, qFull;
  logic [CNT_W-1:0] qCount;

  mpe_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(clear), .evtStrobe(evtStrobe),
    .rdStrobe(rdStrobe), .qEmpty(qEmpty), .qFull(qFull), .ctrl(ctrl)
  );

  mpe_datapath #(.DEPTH(DEPTH), .DELTA_W(DELTA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .dx(dx), .dy(dy),
    .btnLeft(btnLeft), .btnMiddle(btnMiddle), .btnRight(btnRight),
    .rdByte(rdByte), .qEmpty(qEmpty), .qFull(qFull), .qCount(qCount)
  );

  assign dataAvail = ~qEmpty;
endmodule

// File: rtl/mouse_pkt_enc_chk.sv
module mouse_pkt_enc_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             rdStrobe,
  input logic [7:0]       rdByte,
  input logic             dataAvail,
  input logic [CNT_W-1:0] qCount
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W+1)'(qCount) <= (CNT_W+1)'(DEPTH)); // R6

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((CNT_W+1)'(qCount) == (CNT_W+1)'(DEPTH) && !rdStrobe && !clear)
      |=> ((CNT_W+1)'(qCount) == (CNT_W+1)'(DEPTH))); // R6

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dataAvail |-> (rdByte == 8'h00)); // R7

  AST_EMPTY_READ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!dataAvail && rdStrobe && !clear) |=> ((CNT_W+1)'(qCount) <= (CNT_W+1)'(1))); // R7

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !dataAvail); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((CNT_W+1)'(qCount) <= (CNT_W+1)'($past(qCount)) + (CNT_W+1)'(1))
            && ((CNT_W+1)'(qCount) + (CNT_W+1)'(1) >= (CNT_W+1)'($past(qCount)))); // R5
endmodule

bind mouse_pkt_enc mouse_pkt_enc_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .rdStrobe(rdStrobe),
  .rdByte(rdByte), .dataAvail(dataAvail), .qCount(qCount)
);

// File: tb/mouse_pkt_enc_test.sv
`timescale 1ns/1ps
module mouse_pkt_enc_test;
  localparam int DEPTH = 16;
  localparam int DW = 10;
  localparam int NVEC = 8;

  // {buttons L,M,R ; dx ; dy ; header ; X byte ; Y byte}
  localparam logic [46:0] VEC [NVEC] = '{
    {3'b000, 10'h000, 10'h000, 8'h87, 8'h00, 8'h00},
    {3'b100, 10'h005, 10'h003, 8'h83, 8'h05, 8'hFD},
    {3'b010, 10'h3FF, 10'h3FF, 8'h85, 8'hFF, 8'h01},
    {3'b001, 10'h07F, 10'h381, 8'h86, 8'h7F, 8'h7F},
    {3'b111, 10'h080, 10'h080, 8'h80, 8'h7F, 8'h81},
    {3'b000, 10'h380, 10'h380, 8'h87, 8'h81, 8'h7F},
    {3'b110, 10'h1FF, 10'h200, 8'h81, 8'h7F, 8'h7F},
    {3'b011, 10'h200, 10'h1FF, 8'h84, 8'h81, 8'h81}
  };

  logic clk = 0, rst_n = 0, clear = 0, evtStrobe = 0, rdStrobe = 0;
  logic signed [DW-1:0] dx = '0, dy = '0;
  logic btnLeft = 0, btnMiddle = 0, btnRight = 0;
  logic [7:0] rdByte;
  logic dataAvail;
  int vecs = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mouse_pkt_enc #(.DEPTH(DEPTH), .DELTA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .evtStrobe(evtStrobe),
    .dx(dx), .dy(dy), .btnLeft(btnLeft), .btnMiddle(btnMiddle),
    .btnRight(btnRight), .rdStrobe(rdStrobe), .rdByte(rdByte),
    .dataAvail(dataAvail)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  task automatic driveEvt(input int v);
    @(negedge clk);
    {btnLeft, btnMiddle, btnRight} = VEC[v][46:44];
    dx = VEC[v][43:34];
    dy = VEC[v][33:24];
    evtStrobe = 1;
    @(negedge clk);
    evtStrobe = 0;
  endtask

  task automatic sendEvt(input int v);
    driveEvt(v);
    repeat (7) @(negedge clk);
  endtask

  // called at a negedge: check the head byte, then pop it
  task automatic popByte(input string tag, input logic [7:0] exp);
    chk({tag, " R5 avail"}, {7'b0, dataAvail}, 8'h01);
    chk(tag, rdByte, exp);
    rdStrobe = 1;
    @(negedge clk);
    rdStrobe = 0;
  endtask

  task automatic popPkt(input int v);
    popByte("R1 header", VEC[v][23:16]);
    popByte("R2 x", VEC[v][15:8]);
    popByte("R3 y", VEC[v][7:0]);
    popByte("R4 zero4", 8'h00);
    popByte("R4 zero5", 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 avail after reset", {7'b0, dataAvail}, 8'h00);
    chk("R10 byte after reset", rdByte, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      sendEvt(v);
      popPkt(v);
      chk("R5 drained", {7'b0, dataAvail}, 8'h00);
    end

    // R6: 15 bytes fit, only the header of the fourth packet fits, fifth event is lost
    sendEvt(0); sendEvt(1); sendEvt(2); sendEvt(3);
    sendEvt(4);
    popPkt(0); popPkt(1); popPkt(2);
    popByte("R6 last fitting header", 8'h86);
    chk("R6 rest dropped", {7'b0, dataAvail}, 8'h00);
    chk("R7 empty byte", rdByte, 8'h00);

    // R7: read on empty queue changes nothing
    rdStrobe = 1;
    @(negedge clk);
    rdStrobe = 0;
    chk("R7 empty read avail", {7'b0, dataAvail}, 8'h00);
    chk("R7 empty read byte", rdByte, 8'h00);
    sendEvt(1);
    popPkt(1);

    // R8: clear mid-queue
    sendEvt(2);
    popByte("R8 pre-clear header", 8'h85);
    clear = 1;
    @(negedge clk);
    clear = 0;
    chk("R8 cleared avail", {7'b0, dataAvail}, 8'h00);
    chk("R8 cleared byte", rdByte, 8'h00);
    // clear during a burst abandons the packet
    driveEvt(3);
    @(negedge clk);
    clear = 1;
    @(negedge clk);
    clear = 0;
    repeat (6) @(negedge clk);
    chk("R8 burst abandoned", {7'b0, dataAvail}, 8'h00);
    sendEvt(5);
    popPkt(5);

    // R9: second event during a burst is ignored
    driveEvt(6);
    @(negedge clk);
    driveEvt(7);
    repeat (6) @(negedge clk);
    popPkt(6);
    chk("R9 second event ignored", {7'b0, dataAvail}, 8'h00);

    finishRun();
  end
endmodule